// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that finishes every instruction in one clock. Its instruction set is small. Register-to-register ALU operations use the register format. Word loads, word stores and two compare-and-branch forms use the immediate format. The core holds its own program counter, instruction memory, 32-entry register file, ALU, sign extender, branch-target adder, data memory and decoders.

A host fills both memories through one write port while reset is held low, then releases reset. From then on the core runs on its own. The host watches progress on the program-counter tap and reads any architectural register through a separate debug read port.

Field layout of the register format: opcode [31:26], first source [25:21], second source [20:16], destination [15:11], shift amount [10:6] and function [5:0]. The immediate format keeps the opcode and both register fields in the same places and puts a 16-bit immediate in [15:0]. Both memories are indexed by word, using address bits from bit 2 upward. Address bits above the memory's index range are dropped.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0 and every register reads 0. After `rst_n` rises, the PC holds 0 through two rising edges and first advances on the third.
- R2: Opcode 0 with function 32 writes the sum of the registers in [25:21] and [20:16] into the register named by [15:11].
- R3: Opcode 0 with function 34 subtracts ([25:21] minus [20:16]). Function 36 gives bitwise AND, 37 gives bitwise OR, and 42 gives 1 if [25:21] is less than [20:16] as signed values, otherwise 0. Each result goes to register [15:11].
- R4: Opcode 35 reads the data word at (register [25:21] + sign-extended [15:0]) and writes it to register [20:16]. The word index is address bits [DAW+1:2], so higher bits wrap.
- R5: Opcode 43 writes register [20:16] to the data word at (register [25:21] + sign-extended [15:0]). The register file is not written.
- R6: Opcode 4 branches when the two registers are equal. The new PC is PC + 4 + (sign-extended [15:0] shifted left by 2), so negative offsets branch backwards.
- R7: Opcode 5 branches, to the same target as R6, when the two registers differ. When they are equal, execution falls through.
- R8: Every instruction that does not take a branch sets the next PC to PC + 4. An opcode other than 0, 4, 5, 35 or 43 writes neither the register file nor the data memory.
- R9: Register 0 reads as 0 on every port and ignores writes.
- R10: When `host_we` is high, `host_wdata` is written at word `host_addr` on a rising edge. The word goes to data memory if `host_sel_dmem` is 1 and to instruction memory if it is 0. `dbg_rdata` shows the register selected by `dbg_rsel` with no delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset. Assertion takes effect at once; release passes through two flops before reaching the core |
| host_we | input | 1 | Host memory write strobe |
| host_sel_dmem | input | 1 | Write target: 1 selects data memory, 0 selects instruction memory |
| host_addr | input | HAW | Word index for the host write |
| host_wdata | input | 32 | Word written by the host |
| pc_o | output | 32 | Current program counter |
| dbg_rsel | input | 5 | Register index for the debug read |
| dbg_rdata | output | 32 | Contents of register `dbg_rsel` |

## Verification
The bench builds the core with a 32-word instruction memory and a 16-word data memory. With only four index bits in the data memory, a load offset of 68 lands on word 1, so the wrap rule in R4 is exercised. The shrunken memories also keep the program-counter index narrow, which makes the fall-through, forward branch, backward loop and self-loop halt all land on short, hand-checkable addresses. A behavioural model runs alongside the core. The model and the core are compared on every clock, through both the PC tap and a debug register index that sweeps all 32 registers.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_BNE   = 6'd5;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_fn_e;

  typedef enum logic [1:0] {
    CLS_ADDR  = 2'b00,
    CLS_CMP   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     reg_we;
    logic     mem_we;
    logic     branch;
    logic     br_on_ne;
    alu_cls_e cls;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_fn_e    alu_fn
);

  // main decoder: steers every datapath multiplexer per opcode
  always_comb begin
    ctrl = '{dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
             mem_we: 1'b0, branch: 1'b0, br_on_ne: 1'b0, cls: CLS_ADDR};
    case (opcode)
      OPC_REG: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.cls    = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_we  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CLS_CMP;
      end
      OPC_BNE: begin
        ctrl.branch   = 1'b1;
        ctrl.br_on_ne = 1'b1;
        ctrl.cls      = CLS_CMP;
      end
      default: ;
    endcase
  end

  // ALU control: operation class plus function field
  always_comb begin
    alu_fn = ALU_ADD;
    case (ctrl.cls)
      CLS_CMP: alu_fn = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
      default: alu_fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (fn)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b,
  input  logic [AW-1:0] raddr_c,
  output logic [W-1:0]  rdata_c
);

  logic [NREG-1:0][W-1:0] regs;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_flop
      logic         hit;
      logic [W-1:0] q;
      assign hit = we && (waddr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wdata;
      end
      assign regs[i] = q;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_c = regs[raddr_c];

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int HAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic            host_sel_dmem,
  input  logic [HAW-1:0]  host_addr,
  input  logic [31:0]     host_wdata,
  output logic [31:0]     pc_o,
  input  logic [4:0]      dbg_rsel,
  output logic [31:0]     dbg_rdata
);

  // reset: asserted asynchronously, released after two flops
  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  // program counter
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target;
  logic            take_br;

  // instruction memory
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] instr;
  logic            imem_host_we;

  assign imem_host_we = host_we && !host_sel_dmem;

  always_ff @(posedge clk) begin
    if (imem_host_we) imem[host_addr[IAW-1:0]] <= host_wdata;
  end
  assign instr = imem[pc_q[IAW+1:2]];

  // instruction fields
  logic [5:0]  f_op, f_fn;
  logic [4:0]  f_rs, f_rt, f_rd;
  logic [15:0] f_imm;
  logic        unused_shamt;

  assign f_op         = instr[31:26];
  assign f_rs         = instr[25:21];
  assign f_rt         = instr[20:16];
  assign f_rd         = instr[15:11];
  assign f_fn         = instr[5:0];
  assign f_imm        = instr[15:0];
  assign unused_shamt = ^instr[10:6];

  // control
  ctrl_t   ctrl;
  alu_fn_e alu_fn;

  sc_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl),
    .alu_fn (alu_fn)
  );

  // register file
  logic [XLEN-1:0] rs_data, rt_data, wb_data;
  logic [4:0]      wr_sel;

  assign wr_sel = ctrl.dst_rd ? f_rd : f_rt;

  sc_regfile #(.W(XLEN), .NREG(32)) u_rf (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .we      (ctrl.reg_we),
    .waddr   (wr_sel),
    .wdata   (wb_data),
    .raddr_a (f_rs),
    .rdata_a (rs_data),
    .raddr_b (f_rt),
    .rdata_b (rt_data),
    .raddr_c (dbg_rsel),
    .rdata_c (dbg_rdata)
  );

  // execute
  logic [XLEN-1:0] imm_ext, alu_b, alu_y;
  logic            alu_zero;

  assign imm_ext = {{(XLEN-16){f_imm[15]}}, f_imm};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_data;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_data),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: host preload has priority over core stores
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [DAW-1:0]  d_idx;
  logic [XLEN-1:0] d_rdata;
  logic            dmem_host_we;

  assign dmem_host_we = host_we && host_sel_dmem;
  assign d_idx        = alu_y[DAW+1:2];

  always_ff @(posedge clk) begin
    if (dmem_host_we)     dmem[host_addr[DAW-1:0]] <= host_wdata;
    else if (ctrl.mem_we) dmem[d_idx] <= rt_data;
  end
  assign d_rdata = dmem[d_idx];

  assign wb_data = ctrl.wb_mem ? d_rdata : alu_y;

  // next PC
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign take_br   = ctrl.branch && (alu_zero ^ ctrl.br_on_ne);

  always_comb begin
    pc_d = pc_plus4;
    if (take_br) pc_d = br_target;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic        br_taken,
  input logic [31:0] imm_ext,
  input logic [4:0]  ra_addr,
  input logic [31:0] ra_data,
  input logic        reg_wr,
  input logic        mem_wr
);

  // R8: sequential flow advances by one word
  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |=> pc == $past(pc) + 32'd4);

  // R6 / R7: taken branch lands on PC + 4 + offset*4
  assert_br_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> pc == $past(pc) + 32'd4 + {$past(imm_ext[29:0]), 2'b00});

  // R5: a store never writes the register file
  assert_store_nowr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !reg_wr);

  // R9: register 0 reads as zero
  assert_r0_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == 5'd0) |-> (ra_data == 32'd0));

endmodule

bind sc_core sc_core_chk u_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .pc       (pc_q),
  .br_taken (take_br),
  .imm_ext  (imm_ext),
  .ra_addr  (f_rs),
  .ra_data  (rs_data),
  .reg_wr   (ctrl.reg_we),
  .mem_wr   (ctrl.mem_we)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;

  localparam int IW  = 32;
  localparam int DW  = 16;
  localparam int HAW = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            host_we, host_sel_dmem;
  logic [HAW-1:0]  host_addr;
  logic [31:0]     host_wdata;
  logic [31:0]     pc_o;
  logic [4:0]      dbg_rsel;
  logic [31:0]     dbg_rdata;

  always #2.5 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_we       (host_we),
    .host_sel_dmem (host_sel_dmem),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .pc_o          (pc_o),
    .dbg_rsel      (dbg_rsel),
    .dbg_rdata     (dbg_rdata)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural reference state
  logic [31:0] m_reg  [32];
  logic [31:0] m_imem [IW];
  logic [31:0] m_dmem [DW];
  logic [31:0] m_pc;
  int          last_op;
  int          rel_edges;
  bit          released;
  bit          cmp_on;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0:  return "R2/R3";
      35: return "R4";
      43: return "R5";
      4:  return "R6";
      5:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] ins, a, b, imm, nxt, addr, res;
    int op, rs, rt, rd, fn;
    ins  = m_imem[m_pc[6:2]];
    op   = int'(ins[31:26]);
    rs   = int'(ins[25:21]);
    rt   = int'(ins[20:16]);
    rd   = int'(ins[15:11]);
    fn   = int'(ins[5:0]);
    imm  = {{16{ins[15]}}, ins[15:0]};
    a    = m_reg[rs];
    b    = m_reg[rt];
    nxt  = m_pc + 4;
    addr = a + imm;
    last_op = op;
    case (op)
      0: begin
        case (fn)
          34: res = a - b;
          36: res = a & b;
          37: res = a | b;
          42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: res = a + b;
        endcase
        if (rd != 0) m_reg[rd] = res;
      end
      35: if (rt != 0) m_reg[rt] = m_dmem[addr[5:2]];
      43: m_dmem[addr[5:2]] = b;
      4:  if (a == b) nxt = m_pc + 4 + (imm << 2);
      5:  if (a != b) nxt = m_pc + 4 + (imm << 2);
      default: ;
    endcase
    m_pc = nxt;
  endtask

  always @(posedge clk) begin
    if (released) begin
      rel_edges++;
      if (rel_edges >= 3) model_step();
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      if (rel_edges < 3) chk("R1", "pc held after release", pc_o, m_pc);
      else chk(last_op == 4 ? "R6" : last_op == 5 ? "R7" : "R8", "pc", pc_o, m_pc);
      chk(dbg_rsel == 0 ? "R9" : tag_of(last_op), $sformatf("reg %0d", dbg_rsel),
          dbg_rdata, m_reg[dbg_rsel]);
      dbg_rsel = dbg_rsel + 5'd1;
    end
  end

  task automatic host_wr(bit to_d, int idx, logic [31:0] w);
    @(negedge clk);
    host_we       = 1'b1;
    host_sel_dmem = to_d;
    host_addr     = idx[HAW-1:0];
    host_wdata    = w;
    if (to_d) m_dmem[idx] = w;
    else      m_imem[idx] = w;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic peek(int r, logic [31:0] exp, string tag);
    dbg_rsel = r[4:0];
    #1;
    chk(tag, $sformatf("final reg %0d", r), dbg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #25000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] prog [24];
    rst_n = 1'b0; host_we = 1'b0; host_sel_dmem = 1'b0;
    host_addr = '0; host_wdata = '0; dbg_rsel = '0;
    released = 0; cmp_on = 0; rel_edges = 0; last_op = 0; m_pc = '0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    for (int i = 0; i < IW; i++) m_imem[i] = '0;
    for (int i = 0; i < DW; i++) m_dmem[i] = '0;

    prog[0]  = enc_i(35, 0, 1, 0);
    prog[1]  = enc_i(35, 0, 2, 4);
    prog[2]  = enc_i(35, 0, 3, 8);
    prog[3]  = enc_i(35, 0, 4, 68);
    prog[4]  = enc_r(1, 2, 5, 32);
    prog[5]  = enc_r(1, 2, 6, 34);
    prog[6]  = enc_r(3, 2, 7, 36);
    prog[7]  = enc_r(3, 1, 8, 37);
    prog[8]  = enc_r(2, 1, 9, 42);
    prog[9]  = enc_r(1, 2, 10, 42);
    prog[10] = enc_r(1, 1, 0, 32);
    prog[11] = enc_i(43, 1, 5, 12);
    prog[12] = enc_i(35, 0, 11, 16);
    prog[13] = enc_i(4, 1, 2, 5);
    prog[14] = enc_i(5, 1, 2, 2);
    prog[15] = enc_r(1, 1, 12, 32);
    prog[16] = enc_r(2, 2, 12, 32);
    prog[17] = enc_i(63, 0, 16, 8);
    prog[18] = enc_i(43, 1, 2, -5);
    prog[19] = enc_i(35, 0, 13, 0);
    prog[20] = enc_r(1, 1, 15, 32);
    prog[21] = enc_r(14, 1, 14, 32);
    prog[22] = enc_i(5, 14, 15, -2);
    prog[23] = enc_i(4, 0, 0, -1);

    // R10: preload through the host port while reset is held
    for (int i = 0; i < 24; i++) host_wr(1'b0, i, prog[i]);
    host_wr(1'b1, 0, 32'd5);
    host_wr(1'b1, 1, 32'hFFFF_FFFD);
    host_wr(1'b1, 2, 32'h0F0F_00F0);

    // R1: state during reset
    @(negedge clk);
    chk("R1", "pc in reset", pc_o, 32'd0);
    peek(1, 32'd0, "R1");
    peek(31, 32'd0, "R1");
    dbg_rsel = '0;

    @(negedge clk);
    rst_n    = 1'b1;
    released = 1;
    cmp_on   = 1;
    repeat (60) @(negedge clk);
    cmp_on = 0;

    peek(1,  32'd5,        "R10");
    peek(4,  32'hFFFF_FFFD, "R4");
    peek(5,  32'd2,        "R2");
    peek(6,  32'd8,        "R3");
    peek(7,  32'h0F0F_00F0, "R3");
    peek(8,  32'h0F0F_00F5, "R3");
    peek(9,  32'd1,        "R3");
    peek(10, 32'd0,        "R3");
    peek(11, 32'd2,        "R5");
    peek(13, 32'hFFFF_FFFD, "R5");
    peek(12, 32'd0,        "R7");
    peek(14, 32'd10,       "R7");
    peek(16, 32'd0,        "R8");
    peek(0,  32'd0,        "R9");
    chk("R6", "halt pc", pc_o, 32'h0000_005C);
    finish_run();
  end

endmodule